// File: doc/BRIEF.md
# Flash write unlock controller

This block sits between a CPU register port and a program-memory array and stops stray code from starting a write or erase. Software loads a 22-bit write pointer and sets the enable bit in the control register. It must then write the key byte 55h followed by AAh to a dedicated key address. Only after that may it set the start bit. A start attempt from any other history is dropped without effect. The key address stores nothing and always reads back zero.

An accepted start raises a one-cycle start request to the memory array. The same acceptance raises a CPU stall that holds until the array returns its done pulse. When the write ends normally, the start bit clears by itself and a one-cycle completion pulse is raised for an interrupt flag. Two reset inputs behave differently. Power-on reset clears everything. The warm reset, which stands for master-clear and watchdog resets, clears enable and start but keeps the region and erase selections. If the warm reset arrives while a write is in progress, it also leaves a sticky error flag behind for software to inspect.

Top module: `flash_unlock_ctrl`

## Requirements
- R1: While `por_n` is low, the control register, the key sequence and the pointer clear, and `mem_start`, `mem_stall` and `wr_done_pulse` are 0.
- R2: Address 1 is the key port. A write there changes only the key sequence state, and reading address 1 always returns 0.
- R3: A write to the control register (address 0) with bit 1 (start) set starts a write only when the two writes before it were 55h and then AAh to address 1. `mem_start` is then 1 for exactly the one cycle after that write, and `mem_stall` rises in that same cycle.
- R4: A start attempt is ignored unless bit 0 (enable) was already 1 before the control write that carries the start bit.
- R5: Any of the following returns the key sequence to idle: a write to an address other than 1, a byte other than the expected key at address 1, or a control write. A start attempt after any of these has no effect.
- R6: `mem_stall` stays 1 from an accepted start until the done pulse. CPU writes made while it is 1 are ignored.
- R7: When `mem_done` arrives during a write, `mem_stall` drops and start (bit 1) reads 0 in the next cycle, and `wr_done_pulse` is 1 for exactly that one cycle.
- R8: A warm reset (`warm_rst_n` low at a clock edge) clears enable, start, `mem_stall`, `mem_start`, the key sequence and the pointer. It keeps bit 3 (region) and bit 4 (erase). It sets bit 2 (error) if a write was in progress, and leaves bit 2 unchanged otherwise.
- R9: Software clears the error bit by writing 0 to bit 2. Writing 1 to bit 2 never sets it.
- R10: Addresses 2, 3 and 4 hold pointer bits 7:0, 15:8 and 21:16. Pointer bit 21 (bit 5 of address 4) is stored only when `test_mode` is 1. It reads as 0 on `cpu_rdata` and `mem_addr` whenever `test_mode` is 0.
- R11: Control bits 7:5 read as 0. Addresses 5 to 7 store nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on / brown-out reset, active low, asynchronous |
| warm_rst_n | input | 1 | Master-clear / watchdog reset, active low, synchronous |
| test_mode | input | 1 | Allows the top pointer bit to be written and seen |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | ADDR_W | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for `cpu_addr` |
| mem_start | output | 1 | One-cycle start request to the memory array |
| mem_stall | output | 1 | CPU stall while a write is in progress |
| mem_addr | output | PTR_W | Write pointer as seen by the memory array |
| mem_region | output | 1 | Region select bit to the memory array |
| mem_erase | output | 1 | Erase-instead-of-program bit to the memory array |
| mem_done | input | 1 | Done pulse from the memory array |
| wr_done_pulse | output | 1 | One-cycle normal-completion pulse |

## Verification
The hardest situation to reach is a warm reset that lands while a write is still stalled. Random bytes almost never form the key pair, so the random stimulus biases its choices toward 55h/AAh attempts and mixes in occasional corrupting writes. Directed tests start a write and hold back the done pulse from the memory stub, then pull the warm reset in the middle of the stall. After that they check that the error bit stays sticky, that it survives a second warm reset, and that only power-on reset or a software write of 0 clears it.

// File: rtl/flu_pkg.sv
package flu_pkg;

   // register address map
   localparam int FLU_A_CTRL = 0;
   localparam int FLU_A_KEY  = 1;
   localparam int FLU_A_PTR0 = 2;

   // control bit positions
   localparam int FLU_B_WEN   = 0;
   localparam int FLU_B_GO    = 1;
   localparam int FLU_B_ERR   = 2;
   localparam int FLU_B_SEL   = 3;
   localparam int FLU_B_ERASE = 4;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_KEY1  = 2'd1,
      SEQ_ARMED = 2'd2
   } seq_e;

   // packed MSB first so {3'b0, ctrl_t} lines up with the bit positions above
   typedef struct packed {
      logic erase;
      logic sel;
      logic err;
      logic go;
      logic wen;
   } ctrl_t;

endpackage

// File: rtl/flu_unlock_seq.sv
module flu_unlock_seq
   import flu_pkg::*;
#(
   parameter logic [7:0] KEY_A = 8'h55,
   parameter logic [7:0] KEY_B = 8'hAA
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       warm_rst_n,
   input  logic       wr_en,
   input  logic       key_hit,
   input  logic [7:0] wdata,
   output logic       armed
);

   seq_e st_q, st_d;

   always_comb begin
      st_d = SEQ_IDLE;
      if (key_hit) begin
         if (st_q == SEQ_IDLE && wdata == KEY_A)
            st_d = SEQ_KEY1;
         else if (st_q == SEQ_KEY1 && wdata == KEY_B)
            st_d = SEQ_ARMED;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         st_q <= SEQ_IDLE;
      else if (!warm_rst_n)
         st_q <= SEQ_IDLE;
      else if (wr_en)
         st_q <= st_d;
   end

   assign armed = (st_q == SEQ_ARMED);

endmodule

// File: rtl/flu_ctrl_reg.sv
module flu_ctrl_reg
   import flu_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       warm_rst_n,
   input  logic       wr_ctrl,
   input  logic [7:0] wdata,
   input  logic       armed,
   input  logic       mem_done,
   output ctrl_t      ctrl_q,
   output logic       start_q,
   output logic       done_q
);

   logic launch;

   // enable must already be set before the write that carries start
   assign launch = wr_ctrl && armed && wdata[FLU_B_GO] && ctrl_q.wen;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ctrl_q  <= '0;
         start_q <= 1'b0;
         done_q  <= 1'b0;
      end else if (!warm_rst_n) begin
         ctrl_q.wen <= 1'b0;
         ctrl_q.go  <= 1'b0;
         ctrl_q.err <= ctrl_q.err | ctrl_q.go;
         start_q    <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         start_q <= 1'b0;
         done_q  <= 1'b0;
         if (ctrl_q.go && mem_done) begin
            ctrl_q.go <= 1'b0;
            done_q    <= 1'b1;
         end else if (wr_ctrl) begin
            ctrl_q.wen   <= wdata[FLU_B_WEN];
            ctrl_q.sel   <= wdata[FLU_B_SEL];
            ctrl_q.erase <= wdata[FLU_B_ERASE];
            ctrl_q.err   <= ctrl_q.err & wdata[FLU_B_ERR];
            if (launch) begin
               ctrl_q.go <= 1'b1;
               start_q   <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/flu_ptr_reg.sv
module flu_ptr_reg #(
   parameter int PTR_W  = 22,
   parameter int ADDR_W = 3,
   parameter int BASE   = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              warm_rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wdata,
   input  logic              test_mode,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_byte,
   output logic [PTR_W-1:0]  ptr_raw,
   output logic [PTR_W-1:0]  ptr_vis
);

   localparam int NB      = (PTR_W + 7) / 8;
   localparam int PADW    = NB * 8;
   localparam int TOP_LEN = PTR_W - (NB - 1) * 8;
   localparam int TOP_BIT = TOP_LEN - 1;

   logic [PADW-1:0] pad_q;
   logic [PADW-1:0] vis_pad;

   for (genvar k = 0; k < NB; k++) begin : g_byte
      logic [7:0] byte_q;
      logic [7:0] wmask;
      logic       hit;

      assign hit = wr_en && (wr_addr == ADDR_W'(BASE + k));

      if (k == NB - 1) begin : g_top
         localparam logic [7:0] VALID = 8'((16'd1 << TOP_LEN) - 16'd1);
         localparam logic [7:0] GUARD = 8'(16'd1 << TOP_BIT);
         assign wmask = test_mode ? VALID : (VALID & ~GUARD);
      end else begin : g_full
         assign wmask = 8'hFF;
      end

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            byte_q <= '0;
         else if (!warm_rst_n)
            byte_q <= '0;
         else if (hit)
            byte_q <= wdata & wmask;
      end

      assign pad_q[k*8 +: 8] = byte_q;
   end

   assign ptr_raw = pad_q[PTR_W-1:0];
   assign ptr_vis = test_mode ? ptr_raw : {1'b0, ptr_raw[PTR_W-2:0]};
   assign vis_pad = PADW'(ptr_vis);

   always_comb begin
      rd_byte = '0;
      for (int i = 0; i < NB; i++) begin
         if (rd_addr == ADDR_W'(BASE + i))
            rd_byte = vis_pad[i*8 +: 8];
      end
   end

endmodule

// File: rtl/flash_unlock_ctrl.sv
module flash_unlock_ctrl
   import flu_pkg::*;
#(
   parameter int         ADDR_W = 3,
   parameter int         PTR_W  = 22,
   parameter logic [7:0] KEY_A  = 8'h55,
   parameter logic [7:0] KEY_B  = 8'hAA
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              warm_rst_n,
   input  logic              test_mode,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [7:0]        cpu_wdata,
   output logic [7:0]        cpu_rdata,
   output logic              mem_start,
   output logic              mem_stall,
   output logic [PTR_W-1:0]  mem_addr,
   output logic              mem_region,
   output logic              mem_erase,
   input  logic              mem_done,
   output logic              wr_done_pulse
);

   localparam int NB = (PTR_W + 7) / 8;

   if (PTR_W < 9 || PTR_W > 32) begin : g_bad_ptr_w
      $error("flash_unlock_ctrl: PTR_W must lie in 9..32");
   end
   if (FLU_A_PTR0 + NB > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("flash_unlock_ctrl: ADDR_W too small for the pointer bytes");
   end
   if (KEY_A == KEY_B) begin : g_bad_keys
      $error("flash_unlock_ctrl: the two key bytes must differ");
   end

   ctrl_t             ctrl_q;
   logic              acc;
   logic              armed;
   logic [7:0]        ptr_rd;
   logic [PTR_W-1:0]  ptr_raw;
   logic [PTR_W-1:0]  ptr_vis;

   // writes land only when no write is running and no warm reset is active
   assign acc = cpu_we && warm_rst_n && !ctrl_q.go;

   flu_unlock_seq #(
      .KEY_A (KEY_A),
      .KEY_B (KEY_B)
   ) u_seq (
      .clk        (clk),
      .por_n      (por_n),
      .warm_rst_n (warm_rst_n),
      .wr_en      (acc),
      .key_hit    (cpu_addr == ADDR_W'(FLU_A_KEY)),
      .wdata      (cpu_wdata),
      .armed      (armed)
   );

   flu_ctrl_reg u_ctrl (
      .clk        (clk),
      .por_n      (por_n),
      .warm_rst_n (warm_rst_n),
      .wr_ctrl    (acc && cpu_addr == ADDR_W'(FLU_A_CTRL)),
      .wdata      (cpu_wdata),
      .armed      (armed),
      .mem_done   (mem_done),
      .ctrl_q     (ctrl_q),
      .start_q    (mem_start),
      .done_q     (wr_done_pulse)
   );

   flu_ptr_reg #(
      .PTR_W  (PTR_W),
      .ADDR_W (ADDR_W),
      .BASE   (FLU_A_PTR0)
   ) u_ptr (
      .clk        (clk),
      .por_n      (por_n),
      .warm_rst_n (warm_rst_n),
      .wr_en      (acc),
      .wr_addr    (cpu_addr),
      .wdata      (cpu_wdata),
      .test_mode  (test_mode),
      .rd_addr    (cpu_addr),
      .rd_byte    (ptr_rd),
      .ptr_raw    (ptr_raw),
      .ptr_vis    (ptr_vis)
   );

   always_comb begin
      if (cpu_addr == ADDR_W'(FLU_A_CTRL))
         cpu_rdata = {3'b000, ctrl_q};
      else
         cpu_rdata = ptr_rd;
   end

   assign mem_stall  = ctrl_q.go;
   assign mem_addr   = ptr_vis;
   assign mem_region = ctrl_q.sel;
   assign mem_erase  = ctrl_q.erase;

endmodule

// File: rtl/flu_checker.sv
module flu_checker
   import flu_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int PTR_W  = 22
) (
   input logic              clk,
   input logic              por_n,
   input logic              warm_rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [7:0]        cpu_rdata,
   input logic              mem_start,
   input logic              mem_stall,
   input logic              wr_done_pulse,
   input logic              ctrl_err,
   input logic [PTR_W-1:0]  ptr_raw
);

   AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      (cpu_addr == ADDR_W'(FLU_A_KEY)) |-> (cpu_rdata == 8'h00)); // R2

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
      mem_start |=> !mem_start); // R3

   AST_START_WITH_STALL: assert property (@(posedge clk) disable iff (!por_n)
      mem_start |-> mem_stall); // R3

   AST_NO_START_IN_STALL: assert property (@(posedge clk) disable iff (!por_n)
      mem_stall |=> !mem_start); // R6

   AST_PTR_HELD_IN_STALL: assert property (@(posedge clk) disable iff (!por_n)
      (mem_stall && warm_rst_n) |=> $stable(ptr_raw)); // R6

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
      wr_done_pulse |=> !wr_done_pulse); // R7

   AST_DONE_ENDS_STALL: assert property (@(posedge clk) disable iff (!por_n)
      wr_done_pulse |-> ($past(mem_stall) && !mem_stall)); // R7

   AST_WARM_SETS_ERR: assert property (@(posedge clk) disable iff (!por_n)
      (!warm_rst_n && mem_stall) |=> ctrl_err); // R8

   AST_WARM_CLEARS_RUN: assert property (@(posedge clk) disable iff (!por_n)
      !warm_rst_n |=> (!mem_stall && !mem_start && !wr_done_pulse)); // R8

endmodule

bind flash_unlock_ctrl flu_checker #(
   .ADDR_W (ADDR_W),
   .PTR_W  (PTR_W)
) u_flu_chk (
   .clk           (clk),
   .por_n         (por_n),
   .warm_rst_n    (warm_rst_n),
   .cpu_addr      (cpu_addr),
   .cpu_rdata     (cpu_rdata),
   .mem_start     (mem_start),
   .mem_stall     (mem_stall),
   .wr_done_pulse (wr_done_pulse),
   .ctrl_err      (ctrl_q.err),
   .ptr_raw       (ptr_raw)
);

// File: tb/tb_flash_unlock_ctrl.sv
module tb_flash_unlock_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 4;
   localparam int ADDR_W     = 3;
   localparam int PTR_W      = 22;

   logic              clk = 1'b0;
   logic              por_n = 1'b0;
   logic              warm_rst_n = 1'b1;
   logic              test_mode = 1'b0;
   logic              cpu_we = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [7:0]        cpu_wdata = '0;
   logic [7:0]        cpu_rdata;
   logic              mem_start, mem_stall, mem_region, mem_erase, wr_done_pulse;
   logic [PTR_W-1:0]  mem_addr;
   logic              mem_done = 1'b0;

   int  n_run = 0;
   int  n_fail = 0;
   bit  finished = 0;

   // bench model of the programmer-visible state
   int         m_seq = 0;
   bit         m_wen, m_go, m_err, m_sel, m_erase;
   logic [23:0] m_ptr;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_unlock_ctrl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) dut (
      .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .test_mode(test_mode),
      .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .mem_start(mem_start), .mem_stall(mem_stall),
      .mem_addr(mem_addr), .mem_region(mem_region), .mem_erase(mem_erase),
      .mem_done(mem_done), .wr_done_pulse(wr_done_pulse)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic mdl_clear();
      m_seq = 0; m_wen = 0; m_go = 0; m_err = 0; m_sel = 0; m_erase = 0; m_ptr = '0;
   endtask

   function automatic logic [23:0] exp_vis();
      return test_mode ? m_ptr : (m_ptr & 24'h1F_FFFF);
   endfunction

   function automatic logic [7:0] exp_rd(input int a);
      logic [23:0] v;
      v = exp_vis();
      case (a)
         0: return {3'b000, m_erase, m_sel, m_err, m_go, m_wen};
         2: return v[7:0];
         3: return v[15:8];
         4: return v[23:16];
         default: return 8'h00;
      endcase
   endfunction

   // apply one accepted write to the model; returns whether a start follows
   task automatic mdl_write(input int a, input logic [7:0] d, output bit st);
      st = 0;
      if (a == 0) begin
         st = (m_seq == 2) && d[1] && m_wen;
         m_wen = d[0]; m_sel = d[3]; m_erase = d[4]; m_err = m_err & d[2];
         if (st) m_go = 1;
         m_seq = 0;
      end else if (a == 1) begin
         if (m_seq == 0 && d == 8'h55)      m_seq = 1;
         else if (m_seq == 1 && d == 8'hAA) m_seq = 2;
         else                               m_seq = 0;
      end else if (a >= 2 && a <= 4) begin
         logic [7:0] dd;
         dd = d;
         if (a == 4) dd = d & (test_mode ? 8'h3F : 8'h1F);
         m_ptr[(a-2)*8 +: 8] = dd;
         m_seq = 0;
      end else begin
         m_seq = 0;
      end
   endtask

   task automatic raw_write(input int a, input logic [7:0] d);
      @(negedge clk);
      cpu_we = 1'b1; cpu_addr = ADDR_W'(a); cpu_wdata = d;
      @(negedge clk);
      cpu_we = 1'b0;
   endtask

   task automatic wr(input int a, input logic [7:0] d, output bit st);
      raw_write(a, d);
      mdl_write(a, d, st);
      chk(mem_start == st, "R3/R4/R5 start request after write", mem_start, st);
   endtask

   task automatic rd_chk(input int a, input string req);
      logic [7:0] e;
      @(negedge clk);
      cpu_addr = ADDR_W'(a);
      #1;
      e = exp_rd(a);
      chk(cpu_rdata == e, req, cpu_rdata, e);
   endtask

   // fixed-latency memory stub, run after an accepted start
   task automatic complete();
      chk(mem_stall == 1'b1, "R3 stall rises with start", mem_stall, 1);
      repeat (LAT - 1) @(negedge clk);
      chk(mem_stall == 1'b1 && mem_start == 1'b0, "R6 stall held while busy", {mem_stall, mem_start}, 2'b10);
      mem_done = 1'b1;
      @(negedge clk);
      mem_done = 1'b0;
      m_go = 0;
      chk(mem_stall == 1'b0, "R7 stall drops after done", mem_stall, 0);
      chk(wr_done_pulse == 1'b1, "R7 completion pulse", wr_done_pulse, 1);
      @(negedge clk);
      chk(wr_done_pulse == 1'b0, "R7 completion pulse one cycle", wr_done_pulse, 0);
   endtask

   task automatic warm_reset();
      @(negedge clk);
      warm_rst_n = 1'b0;
      @(negedge clk);
      warm_rst_n = 1'b1;
      m_err = m_err | m_go; m_wen = 0; m_go = 0; m_seq = 0; m_ptr = '0;
   endtask

   task automatic unlock_start(input logic [7:0] cd, output bit st);
      bit s;
      wr(1, 8'h55, s);
      wr(1, 8'hAA, s);
      wr(0, cd, st);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      bit st;
      void'($urandom(32'd20240611));
      mdl_clear();
      repeat (3) @(negedge clk);
      chk({mem_start, mem_stall, wr_done_pulse} == 3'b000, "R1 outputs low in reset",
          {mem_start, mem_stall, wr_done_pulse}, 0);
      por_n = 1'b1;
      rd_chk(0, "R1 control cleared by power-on reset");
      rd_chk(2, "R1 pointer low cleared");
      rd_chk(4, "R1 pointer upper cleared");
      chk(mem_addr == '0, "R1 mem_addr cleared", mem_addr, 0);

      // R2: key port stores nothing
      wr(1, 8'h55, st);
      rd_chk(1, "R2 key address reads zero");
      rd_chk(6, "R11 unused address reads zero");

      // R4: enable not yet set when start is requested
      wr(0, 8'h00, st);
      unlock_start(8'h03, st);
      chk(st == 0 && mem_stall == 0, "R4 start ignored without prior enable", mem_stall, 0);
      rd_chk(0, "R4 enable set but start clear");

      // R3 and R7: valid sequence
      wr(2, 8'h5A, st);
      unlock_start(8'h0B, st);
      chk(st == 1, "R3 valid sequence starts", st, 1);
      complete();
      rd_chk(0, "R7 start bit clear after done");
      chk(mem_region == 1'b1, "R3 region select forwarded", mem_region, 1);

      // R5: corrupted sequences
      wr(1, 8'h55, st); wr(3, 8'h12, st); wr(1, 8'hAA, st); wr(0, 8'h03, st);
      chk(mem_stall == 0, "R5 intervening write breaks sequence", mem_stall, 0);
      wr(1, 8'h55, st); wr(1, 8'h55, st); wr(1, 8'hAA, st); wr(0, 8'h03, st);
      chk(mem_stall == 0, "R5 repeated first key breaks sequence", mem_stall, 0);
      wr(1, 8'h55, st); wr(1, 8'hAB, st); wr(0, 8'h03, st);
      chk(mem_stall == 0, "R5 wrong second key", mem_stall, 0);
      wr(0, 8'h03, st);
      chk(mem_stall == 0, "R5 start without sequence", mem_stall, 0);

      // R6: writes during stall are dropped
      unlock_start(8'h03, st);
      raw_write(2, 8'hC3);
      raw_write(0, 8'h00);
      repeat (LAT - 3) @(negedge clk);
      mem_done = 1'b1;
      @(negedge clk);
      mem_done = 1'b0;
      m_go = 0;
      rd_chk(2, "R6 pointer write during stall ignored");
      rd_chk(0, "R6 control write during stall ignored");

      // R8: warm reset mid-write
      wr(0, 8'h19, st);
      unlock_start(8'h1B, st);
      chk(st == 1, "R8 setup start", st, 1);
      @(negedge clk);
      warm_reset();
      chk(mem_stall == 0 && mem_start == 0, "R8 warm reset stops write", mem_stall, 0);
      rd_chk(0, "R8 error set, enable and start clear, region/erase kept");
      rd_chk(2, "R8 pointer cleared by warm reset");
      @(negedge clk); mem_done = 1'b1; @(negedge clk); mem_done = 1'b0;
      chk(wr_done_pulse == 0, "R8 no completion after aborted write", wr_done_pulse, 0);
      warm_reset();
      rd_chk(0, "R8 error survives idle warm reset");

      // R9: error clearing
      wr(0, 8'h04, st);
      rd_chk(0, "R9 writing one keeps error");
      wr(0, 8'h00, st);
      rd_chk(0, "R9 writing zero clears error");
      wr(0, 8'h04, st);
      rd_chk(0, "R9 writing one does not set error");

      // R10: top pointer bit
      test_mode = 1'b1;
      wr(4, 8'hFF, st);
      rd_chk(4, "R10 top bit stored in test mode");
      chk(mem_addr[21] == 1'b1, "R10 mem_addr top bit in test mode", mem_addr[21], 1);
      test_mode = 1'b0;
      rd_chk(4, "R10 top bit hidden outside test mode");
      chk(mem_addr[21] == 1'b0, "R10 mem_addr top bit hidden", mem_addr[21], 0);
      wr(4, 8'hFF, st);
      test_mode = 1'b1;
      rd_chk(4, "R10 top bit not stored outside test mode");
      test_mode = 1'b0;

      // R1: power-on reset clears the sticky error too
      wr(0, 8'h19, st);
      unlock_start(8'h1B, st);
      warm_reset();
      @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1;
      mdl_clear();
      rd_chk(0, "R1 power-on reset clears error");

      // constrained random phase
      for (int it = 0; it < 300; it++) begin
         int op;
         op = $urandom % 8;
         if (op < 4) begin
            logic [7:0] d1, d2, cd;
            d1 = ($urandom % 6 == 0) ? 8'($urandom) : 8'h55;
            wr(1, d1, st);
            if ($urandom % 5 == 0) wr(2 + ($urandom % 6), 8'($urandom), st);
            d2 = ($urandom % 6 == 0) ? 8'($urandom) : 8'hAA;
            wr(1, d2, st);
            cd = 8'($urandom % 32);
            if ($urandom % 4 != 0) cd[1] = 1'b1;
            if ($urandom % 3 != 0) cd[0] = 1'b1;
            wr(0, cd, st);
            if (st) begin
               if ($urandom % 6 == 0) begin
                  @(negedge clk);
                  warm_reset();
               end else begin
                  complete();
               end
            end
         end else if (op < 7) begin
            int a;
            logic [7:0] d;
            a = $urandom % 8;
            case ($urandom % 3)
               0: d = 8'h55;
               1: d = 8'hAA;
               default: d = 8'($urandom);
            endcase
            wr(a, d, st);
            if (st) complete();
         end else begin
            warm_reset();
         end
         rd_chk(0, "R8/R9/R11 random control readback");
         rd_chk(2 + ($urandom % 3), "R10 random pointer readback");
         chk(mem_addr == exp_vis()[PTR_W-1:0], "R10 random mem_addr", mem_addr, exp_vis());
         chk(mem_erase == m_erase, "R11 erase bit forwarded", mem_erase, m_erase);
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule